// File: doc/BRIEF.md
# UART Receive Queue with Channel Routing

This block sits between a UART's line deserializer, its bus-facing data register and its transmit line. It holds received bytes in a small first-in first-out queue and decides where each byte goes. That decision depends on a two-bit channel mode: normal operation, automatic echo, local loopback or remote loopback. A byte from the line can be queued, sent back out on the transmit line, or ignored. A byte written by software can be transmitted, looped into the queue, or dropped.

The block owns a six-bit control register. That register gates the receiver and the transmitter, and it carries a self-clearing bit that empties the queue. The block reports the fill level of the queue and its empty, full and trigger flags. It also produces two single-cycle event pulses. The overrun pulse marks a byte lost to a full queue. The timeout pulse fires when a set number of character periods pass with no new byte after the last accepted one. A frame timer outside the block supplies one pulse per character period.

Top module: `rxq_route`

## Requirements
- R1: Line bytes (`line_valid_i`) are queued in modes 0 (normal) and 1 (echo). They appear on `tx_valid_o`/`tx_data_o` in the same cycle in modes 1 and 3 (remote loopback). In mode 2 (local loopback) they are ignored.
- R2: A data write (`bus_wr_i`) is transmitted in the same cycle in mode 0 and queued in mode 2. In modes 1 and 3 it is dropped and has no effect on the queue or the transmit line.
- R3: The receiver is on only while control bit 2 is 1 and control bit 3 is 0, so bit 3 overrides bit 2. While the receiver is off, no byte is queued and reads neither return data nor remove an entry.
- R4: The transmit path is on only while control bit 4 is 1 and control bit 5 is 0. While it is off, `tx_valid_o` stays low.
- R5: The queue holds up to 16 bytes and returns them in arrival order. `count_o` follows each accepted push and pop on the next clock edge. `empty_o` means a count of 0 and `full_o` means a count of 16.
- R6: A byte offered while the queue is full, with no read in the same cycle, is discarded. `overrun_o` is then high for exactly the following cycle, and the stored contents are unchanged.
- R7: A read and a push in the same cycle on a full queue act as a pop followed by a push. There is no overrun and the count stays at 16.
- R8: A read while the queue is empty, or while the receiver is off, returns 0 on `rd_data_o` and leaves the count unchanged.
- R9: `trig_o` is high whenever `count_o` is greater than or equal to `trig_level_i`.
- R10: Each accepted byte rearms a timer. The fourth `char_tick_i` pulse after the last accepted byte makes `timeout_o` high for the one following cycle. Further ticks raise nothing until another byte is accepted.
- R11: Writing control bit 0 as 1 empties the queue and disarms the timer at the next clock edge. Bit 0 reads back 0 from then on, and a byte offered during that cycle is lost.
- R12: A line break (`line_break_i`) is queued as the byte 0x00 in modes 0 and 1, whatever the value on `line_data_i`, and is never retransmitted.
- R13: After reset, the control register reads 0x28 (both disables set), the queue is empty and no event is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 6 | Control write data: bit0 queue clear, bit2 rx on, bit3 rx off, bit4 tx on, bit5 tx off |
| ctrl_o | output | 6 | Control register contents |
| line_valid_i | input | 1 | Byte received from the line deserializer |
| line_data_i | input | 8 | Received byte |
| line_break_i | input | 1 | Break condition received from the line |
| bus_wr_i | input | 1 | Write to the data register |
| bus_wdata_i | input | 8 | Data register write byte |
| bus_rd_i | input | 1 | Read of the data register; pops one entry |
| rd_data_o | output | 8 | Read byte, valid in the cycle of `bus_rd_i` |
| tx_valid_o | output | 1 | Byte to send on the transmit line |
| tx_data_o | output | 8 | Byte to send |
| char_tick_i | input | 1 | One pulse per character period |
| trig_level_i | input | 5 | Trigger level for `trig_o` |
| count_o | output | 5 | Entries in the queue |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| trig_o | output | 1 | Count at or above the trigger level |
| overrun_o | output | 1 | Byte lost to a full queue (one-cycle pulse) |
| timeout_o | output | 1 | Receive timeout (one-cycle pulse) |

## Verification
The pair of functions that can land in the same cycle is a push and a pop on a queue that is already full. To set this up, the bench fills all 16 entries. It then drives a line byte and a data read in the same cycle. The verdict rests on three observations: the read returns the oldest byte, no overrun pulse follows, and the count stays at 16. Draining the queue afterwards must produce the remaining bytes in order with the new byte last. This also shows that an overrun byte offered earlier never entered the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LLOOP  = 2'd2,
    CH_RLOOP  = 2'd3
  } ch_mode_e;

  localparam int CTRL_W      = 6;
  localparam int CB_CLR      = 0;
  localparam int CB_RX_ON    = 2;
  localparam int CB_RX_OFF   = 3;
  localparam int CB_TX_ON    = 4;
  localparam int CB_TX_OFF   = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'h28;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rx_on_o,
  output logic              tx_on_o,
  output logic              clr_o
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_i) begin
      ctrl_q    <= wdata_i;
      ctrl_q[1] <= 1'b0;
    end else if (ctrl_q[CB_CLR]) begin
      ctrl_q[CB_CLR] <= 1'b0;  // self-clear once applied
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rx_on_o = ctrl_q[CB_RX_ON] & ~ctrl_q[CB_RX_OFF];
  assign tx_on_o = ctrl_q[CB_TX_ON] & ~ctrl_q[CB_TX_OFF];
  assign clr_o   = ctrl_q[CB_CLR];

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          ovr_o,
  output logic          accept_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          is_full, is_empty, do_pop, do_push;

  assign is_full  = (cnt_q == FULL_C);
  assign is_empty = (cnt_q == '0);
  assign do_pop   = pop_i & ~is_empty & ~clr_i;
  // pop frees a slot before the push lands
  assign do_push  = push_i & ~clr_i & (~is_full | do_pop);
  assign ovr_o    = push_i & ~clr_i & is_full & ~do_pop;
  assign accept_o = do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = cnt_q;

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TMO_CHARS = 4,
  localparam int TW       = (TMO_CHARS > 1) ? $clog2(TMO_CHARS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rearm_i,
  input  logic tick_i,
  output logic fire_o
);

  localparam logic [TW-1:0] END_C = TW'(TMO_CHARS - 1);

  logic          armed_q, fire_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (clr_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (rearm_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
        if (cnt_q == END_C) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
          fire_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/rxq_route.sv
module rxq_route
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              line_valid_i,
  input  logic [7:0]        line_data_i,
  input  logic              line_break_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [7:0]        rd_data_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              char_tick_i,
  input  logic [CW-1:0]     trig_level_i,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              trig_o,
  output logic              overrun_o,
  output logic              timeout_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  ch_mode_e      mode;
  logic          rx_on, tx_on, clr;
  logic          line_any, rx_from_line, tx_from_line;
  logic          push, pop, ovr, accept, ovr_q;
  logic [7:0]    line_byte, push_data, head;
  logic [CW-1:0] cnt;

  assign mode = ch_mode_e'(mode_i);

  rxq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl_o),
    .rx_on_o (rx_on),
    .tx_on_o (tx_on),
    .clr_o   (clr)
  );

  // break stores a zero byte and is not echoed
  assign line_any     = line_valid_i | line_break_i;
  assign line_byte    = line_break_i ? 8'h00 : line_data_i;
  assign rx_from_line = (mode == CH_NORMAL) || (mode == CH_ECHO);
  assign tx_from_line = (mode == CH_ECHO) || (mode == CH_RLOOP);

  always_comb begin
    push      = 1'b0;
    push_data = line_byte;
    if (rx_on) begin
      if (rx_from_line && line_any) begin
        push = 1'b1;
      end else if (mode == CH_LLOOP && bus_wr_i) begin
        push      = 1'b1;
        push_data = bus_wdata_i;
      end
    end
  end

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = 8'h00;
    if (tx_on) begin
      if (mode == CH_NORMAL && bus_wr_i) begin
        tx_valid_o = 1'b1;
        tx_data_o  = bus_wdata_i;
      end else if (tx_from_line && line_valid_i && !line_break_i) begin
        tx_valid_o = 1'b1;
        tx_data_o  = line_data_i;
      end
    end
  end

  assign pop = bus_rd_i & rx_on;

  rxq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .push_i   (push),
    .wdata_i  (push_data),
    .pop_i    (pop),
    .head_o   (head),
    .count_o  (cnt),
    .ovr_o    (ovr),
    .accept_o (accept)
  );

  rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .rearm_i (accept),
    .tick_i  (char_tick_i),
    .fire_o  (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= ovr;
  end

  assign rd_data_o = (rx_on && cnt != '0) ? head : 8'h00;
  assign count_o   = cnt;
  assign empty_o   = (cnt == '0);
  assign full_o    = (cnt == FULL_C);
  assign trig_o    = (cnt >= trig_level_i);
  assign overrun_o = ovr_q;

endmodule

// File: rtl/rxq_route_chk.sv
module rxq_route_chk #(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          bus_rd_i,
  input logic [5:0]    ctrl_o,
  input logic [7:0]    rd_data_o,
  input logic          tx_valid_o,
  input logic          char_tick_i,
  input logic [CW-1:0] count_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          overrun_o,
  input logic          timeout_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_C);

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_o[0]) |-> (count_o == $past(count_o)) ||
                          (count_o == $past(count_o) + CW'(1)) ||
                          (count_o == $past(count_o) - CW'(1)));

  assert_overrun_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full_o) && (count_o == $past(count_o)));

  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && empty_o) |-> rd_data_o == 8'h00);

  assert_rx_off_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !(ctrl_o[2] && !ctrl_o[3]) && !ctrl_o[0]) |=> count_o == $past(count_o));

  assert_tx_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ctrl_o[4] && !ctrl_o[5]);

  assert_lloop_no_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> !tx_valid_o);

  assert_clear_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |=> count_o == '0);

  assert_timeout_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(char_tick_i));

endmodule

bind rxq_route rxq_route_chk #(.DEPTH(DEPTH), .TMO_CHARS(TMO_CHARS)) u_chk (.*);

// File: tb/rxq_route_test.sv
`timescale 1ns/1ps
module rxq_route_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       ctrl_wr_i = 1'b0;
  logic [5:0] ctrl_wdata_i = '0;
  logic [5:0] ctrl_o;
  logic       line_valid_i = 1'b0;
  logic [7:0] line_data_i = '0;
  logic       line_break_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       char_tick_i = 1'b0;
  logic [4:0] trig_level_i = 5'd16;
  logic [4:0] count_o;
  logic       empty_o, full_o, trig_o, overrun_o, timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  logic       last_txv;
  logic [7:0] last_txd;
  logic [7:0] rd;

  always #2.5 clk_i = ~clk_i;

  rxq_route uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic line_send(input logic [7:0] d, input logic brk);
    line_valid_i = ~brk; line_break_i = brk; line_data_i = d;
    #1; last_txv = tx_valid_o; last_txd = tx_data_o;
    @(negedge clk_i);
    line_valid_i = 1'b0; line_break_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_wr_i = 1'b1; bus_wdata_i = d;
    #1; last_txv = tx_valid_o; last_txd = tx_data_o;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] d);
    bus_rd_i = 1'b1;
    #1; d = rd_data_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic tick();
    char_tick_i = 1'b1;
    @(negedge clk_i);
    char_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 ctrl", ctrl_o, 6'h28);
    chk("R13 count", count_o, 0);
    chk("R13 empty", empty_o, 1);
    chk("R13 full", full_o, 0);
    chk("R13 events", {overrun_o, timeout_o}, 0);
  endtask

  task automatic t_normal();
    mode_i = 2'd0;
    wr_ctrl(6'h14);
    line_send(8'h11, 0); chk("R1 normal no tx", last_txv, 0);
    line_send(8'h22, 0);
    line_send(8'h33, 0);
    chk("R5 count 3", count_o, 3);
    chk("R5 not empty", empty_o, 0);
    bus_write(8'hA5);
    chk("R2 normal tx", {last_txv, last_txd}, {1'b1, 8'hA5});
    chk("R2 normal not queued", count_o, 3);
    bus_read(rd); chk("R5 order 0", rd, 8'h11);
    bus_read(rd); chk("R5 order 1", rd, 8'h22);
    bus_read(rd); chk("R5 order 2", rd, 8'h33);
    chk("R5 empty", empty_o, 1);
    bus_read(rd); chk("R8 empty read", rd, 0);
    chk("R8 count kept", count_o, 0);
  endtask

  task automatic t_modes();
    mode_i = 2'd1;
    line_send(8'h5C, 0);
    chk("R1 echo tx", {last_txv, last_txd}, {1'b1, 8'h5C});
    chk("R1 echo queued", count_o, 1);
    bus_write(8'h90);
    chk("R2 echo drop tx", last_txv, 0);
    chk("R2 echo drop queue", count_o, 1);
    bus_read(rd); chk("R1 echo data", rd, 8'h5C);
    mode_i = 2'd2;
    line_send(8'h77, 0);
    chk("R1 lloop line tx", last_txv, 0);
    chk("R1 lloop line ignored", count_o, 0);
    bus_write(8'h3E);
    chk("R2 lloop no tx", last_txv, 0);
    chk("R2 lloop queued", count_o, 1);
    bus_read(rd); chk("R2 lloop data", rd, 8'h3E);
    mode_i = 2'd3;
    line_send(8'h42, 0);
    chk("R1 rloop tx", {last_txv, last_txd}, {1'b1, 8'h42});
    chk("R1 rloop not queued", count_o, 0);
    bus_write(8'h6B);
    chk("R2 rloop drop", {last_txv, 3'b0, count_o}, 0);
    mode_i = 2'd0;
  endtask

  task automatic t_gating();
    wr_ctrl(6'h1C);
    line_send(8'h01, 0);
    chk("R3 disable wins", count_o, 0);
    wr_ctrl(6'h14);
    line_send(8'h61, 0);
    chk("R3 enabled push", count_o, 1);
    wr_ctrl(6'h1C);
    bus_read(rd);
    chk("R8 rx off read 0", rd, 0);
    chk("R3 rx off no pop", count_o, 1);
    wr_ctrl(6'h14);
    bus_read(rd); chk("R3 read after on", rd, 8'h61);
    wr_ctrl(6'h34);
    bus_write(8'hC3); chk("R4 tx off wins", last_txv, 0);
    wr_ctrl(6'h04);
    bus_write(8'hC4); chk("R4 tx not on", last_txv, 0);
    wr_ctrl(6'h14);
    bus_write(8'hC5); chk("R4 tx on", {last_txv, last_txd}, {1'b1, 8'hC5});
  endtask

  task automatic t_trigger();
    trig_level_i = 5'd0;
    #1; chk("R9 level 0 empty", trig_o, 1);
    trig_level_i = 5'd3;
    line_send(8'hA0, 0);
    line_send(8'hA1, 0);
    chk("R9 below", trig_o, 0);
    line_send(8'hA2, 0);
    chk("R9 equal", trig_o, 1);
    wr_ctrl(6'h15);
    @(negedge clk_i);
    chk("R9 after clear", trig_o, 0);
    trig_level_i = 5'd16;
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) line_send(8'(i + 1), 0);
    chk("R5 full count", count_o, 16);
    chk("R5 full flag", full_o, 1);
    chk("R9 level 16", trig_o, 1);
    chk("R6 no overrun yet", overrun_o, 0);
    line_send(8'hEE, 0);
    chk("R6 overrun pulse", overrun_o, 1);
    chk("R6 count kept", count_o, 16);
    line_valid_i = 1'b1; line_data_i = 8'hDD; bus_rd_i = 1'b1;
    #1; rd = rd_data_o;
    @(negedge clk_i);
    line_valid_i = 1'b0; bus_rd_i = 1'b0;
    chk("R7 head on collide", rd, 8'h01);
    chk("R7 no overrun", overrun_o, 0);
    chk("R7 count 16", count_o, 16);
    for (int i = 2; i <= 16; i++) begin
      bus_read(rd); chk("R6 drain order", rd, 32'(i));
    end
    bus_read(rd); chk("R7 pushed last", rd, 8'hDD);
    chk("R6 empty after drain", empty_o, 1);
  endtask

  task automatic t_timeout();
    line_send(8'h10, 0);
    tick(); tick(); tick();
    chk("R10 not yet", timeout_o, 0);
    line_send(8'h11, 0);
    tick(); tick(); tick();
    chk("R10 rearmed", timeout_o, 0);
    tick();
    chk("R10 fires", timeout_o, 1);
    @(negedge clk_i);
    chk("R10 one cycle", timeout_o, 0);
    tick(); tick(); tick(); tick(); tick();
    chk("R10 no refire", timeout_o, 0);
  endtask

  task automatic t_clear();
    line_send(8'h21, 0);
    wr_ctrl(6'h15);
    chk("R11 bit seen", ctrl_o[0], 1);
    chk("R11 count before", count_o, 3);
    @(negedge clk_i);
    chk("R11 emptied", count_o, 0);
    chk("R11 bit self-clears", ctrl_o, 6'h14);
    tick(); tick(); tick(); tick();
    chk("R11 timer disarmed", timeout_o, 0);
  endtask

  task automatic t_break();
    mode_i = 2'd1;
    line_send(8'h99, 1);
    chk("R12 break not echoed", last_txv, 0);
    chk("R12 break queued", count_o, 1);
    bus_read(rd); chk("R12 zero byte", rd, 0);
    mode_i = 2'd0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_modes();
    t_gating();
    t_trigger();
    t_full();
    t_timeout();
    t_clear();
    t_break();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule